// File: doc/BRIEF.md
# Prescaled Free-Running Counter with Coherent Byte Reads

This block keeps a 16-bit up-counter that runs without stopping. A fixed divide-by-four prescaler sits in front of it, so the count steps once every four bus clocks. One full cycle of the count therefore spans 262,144 bus clocks. Software reads the count over an 8-bit register interface as two bytes. Reading the high byte freezes a copy of the low byte. The byte read after it then belongs to the same 16-bit sample, even if the counter has stepped in between.

When the count wraps from all ones to zero, an overflow flag is set. If the overflow interrupt enable is set, this flag drives an interrupt request. To clear the flag, software reads the status register while the flag is set, and then reads the primary low byte. A second register pair returns the same count with its own private latch. Reads of that second pair never take part in clearing the flag. This lets a monitor task sample the time without disturbing the interrupt handshake.

Top module: `freerun_timer`

## Requirements
- R1: Reset sets the count to 0xFFFC, so the high byte reads 0xFF and the low byte reads 0xFC. It also clears the overflow flag, the interrupt enable, both byte latches and the clear handshake. While reset is released, irq is 0.
- R2: The count rises by exactly one on every fourth rising clock edge after reset is released, and holds its value on all other edges.
- R3: Writes to addresses 0 to 4 change neither the count, the byte latches nor the flag. Only address 5 is writable.
- R4: If no high-byte read is pending on a pair, a low-byte read returns the live low byte of the count.
- R5: A read of a pair's high byte (primary at address 0, alternate at address 2) captures the current low byte. Low-byte reads of that pair (address 1 or 3) then return the captured byte. Further high-byte reads before that low-byte read do not refresh the capture. The low-byte read releases it.
- R6: On the edge where the count wraps from 0xFFFF to 0x0000, the overflow flag is set. The flag is bit 7 of the status register at address 4, and the other status bits read 0.
- R7: irq is 1 exactly when the overflow flag is 1 and the interrupt enable is 1. The enable is bit 0 of the control register at address 5. It is written through wr_en and read back at the same position, and the other control bits read 0.
- R8: The flag clears only on a primary low-byte read (address 1) that follows a status read made while the flag was set. High-byte reads do not clear the flag.
- R9: The alternate pair (addresses 2 and 3) keeps its own latch, separate from the primary pair. Reads of the alternate pair never arm or complete the flag clear.
- R10: If a wrap occurs on the same edge as the low-byte read that would complete the clear, the flag stays 1. The handshake is then dropped, so a new status read is needed before a low-byte read can clear the flag.
- R11: rd_data shows the addressed register in the same cycle that rd_en is high. It reads 0 when rd_en is low or the address is 6 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| rd_en | input | 1 | Read strobe; side effects occur at the clock edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from address and strobe |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that each cycle carries at most one access, so the bus never reads and writes in the same cycle. They also assume the address is stable for the whole cycle that its strobe is high. The stimulus changes address and strobes only on the falling edge, and it issues either a read, a write or an idle cycle, never a mix. The assertions also take the prescaler phase to be the one that reset leaves behind. The stimulus therefore lines up the rollover-collision case by counting cycles since reset, and it never assumes a phase of its own.

// File: rtl/frt_pkg.sv
package frt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd0;
   localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
   localparam logic [ADDR_W-1:0] A_ALT_HI = 3'd2;
   localparam logic [ADDR_W-1:0] A_ALT_LO = 3'd3;
   localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;

   localparam int STAT_FLAG_BIT = 7;
   localparam int CTRL_IE_BIT   = 0;

   typedef struct packed {
      logic pri_hi;
      logic pri_lo;
      logic alt_hi;
      logic alt_lo;
      logic stat;
      logic ctrl_wr;
   } strobe_t;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("frt_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_bypass
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase <= '0;
         end else if (phase == LAST) begin
            phase <= '0;
         end else begin
            phase <= phase + 1'b1;
         end
      end

      assign tick = (phase == LAST);

      // R2
      single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
   parameter int W = 16,
   parameter logic [W-1:0] INIT = 16'hFFFC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   output logic [W-1:0] count,
   output logic         wrap
);
   if (W < 2) begin : g_bad_w
      $error("frt_counter: W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= INIT;
      end else if (tick) begin
         count <= count + 1'b1;
      end
   end

   assign wrap = tick && (&count);

   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count == $past(count) + 1'b1));
   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));
endmodule

// File: rtl/frt_read_pair.sv
module frt_read_pair #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_hi,
   input  logic          rd_lo,
   input  logic [BW-1:0] live_lo,
   output logic [BW-1:0] lo_view
);
   logic [BW-1:0] held;
   logic          pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held    <= '0;
         pending <= 1'b0;
      end else if (rd_hi && !pending) begin
         held    <= live_lo;
         pending <= 1'b1;
      end else if (rd_lo) begin
         pending <= 1'b0;
      end
   end

   assign lo_view = pending ? held : live_lo;

   // R5
   no_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && rd_hi) |=> $stable(held));
   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !rd_hi) |=> !pending);
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic rd_stat,
   input  logic rd_lo,
   output logic flag
);
   logic armed;
   logic do_clear;

   assign do_clear = armed && rd_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (wrap) begin
            flag  <= 1'b1;
            armed <= 1'b0;
         end else if (do_clear) begin
            flag  <= 1'b0;
            armed <= 1'b0;
         end else if (rd_stat && flag) begin
            armed <= 1'b1;
         end
      end
   end

   // R6
   set_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag);
   // R8
   keep_without_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !rd_lo) |=> flag);
   // R8
   clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(armed));
   // R10
   collide_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && rd_lo) |=> (flag && !armed));
endmodule

// File: rtl/freerun_timer.sv
module freerun_timer #(
   parameter int CNT_W = 16,
   parameter int PRESCALE = 4,
   parameter logic [CNT_W-1:0] RESET_COUNT = 16'hFFFC
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] reg_addr,
   input  logic       rd_en,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       irq
);
   import frt_pkg::*;

   localparam int HALF = CNT_W / 2;

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("freerun_timer: CNT_W must equal two bus bytes");
   end

   strobe_t          stb;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] count;
   logic [HALF-1:0]  pri_lo_view;
   logic [HALF-1:0]  alt_lo_view;
   logic             flag;
   logic             ie_q;
   logic             ctrl_unused;

   always_comb begin
      stb         = '0;
      stb.pri_hi  = rd_en && (reg_addr == A_CNT_HI);
      stb.pri_lo  = rd_en && (reg_addr == A_CNT_LO);
      stb.alt_hi  = rd_en && (reg_addr == A_ALT_HI);
      stb.alt_lo  = rd_en && (reg_addr == A_ALT_LO);
      stb.stat    = rd_en && (reg_addr == A_STAT);
      stb.ctrl_wr = wr_en && (reg_addr == A_CTRL);
   end

   frt_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   frt_counter #(.W(CNT_W), .INIT(RESET_COUNT)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .count(count),
      .wrap (wrap)
   );

   frt_read_pair #(.BW(HALF)) u_pri (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_hi  (stb.pri_hi),
      .rd_lo  (stb.pri_lo),
      .live_lo(count[HALF-1:0]),
      .lo_view(pri_lo_view)
   );

   frt_read_pair #(.BW(HALF)) u_alt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_hi  (stb.alt_hi),
      .rd_lo  (stb.alt_lo),
      .live_lo(count[HALF-1:0]),
      .lo_view(alt_lo_view)
   );

   frt_ovf_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap   (wrap),
      .rd_stat(stb.stat),
      .rd_lo  (stb.pri_lo),
      .flag   (flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
      end else if (stb.ctrl_wr) begin
         ie_q <= wr_data[CTRL_IE_BIT];
      end
   end

   assign ctrl_unused = ^wr_data;

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (reg_addr)
            A_CNT_HI: rd_data = count[CNT_W-1:HALF];
            A_CNT_LO: rd_data = pri_lo_view;
            A_ALT_HI: rd_data = count[CNT_W-1:HALF];
            A_ALT_LO: rd_data = alt_lo_view;
            A_STAT:   rd_data[STAT_FLAG_BIT] = flag;
            A_CTRL:   rd_data[CTRL_IE_BIT] = ie_q;
            default:  rd_data = '0;
         endcase
      end
   end

   assign irq = flag && ie_q;

   // R7
   irq_off_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == A_CTRL && !wr_data[CTRL_IE_BIT]) |=> !irq);
   // R3
   write_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && !tick) |=> $stable(count));
   // R9
   alt_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && rd_en && reg_addr == A_ALT_LO) |=> flag);
endmodule

// File: tb/freerun_timer_test.sv
module freerun_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_slow;
   logic [7:0] rd_fast;
   logic       irq_slow;
   logic       irq_fast;

   always #(CLK_PERIOD / 2) clk = ~clk;

   freerun_timer uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_slow), .irq(irq_slow)
   );

   freerun_timer #(.PRESCALE(1)) uut_fast (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_fast), .irq(irq_fast)
   );

   // behavioural reference, index 0 = divide by 4, index 1 = divide by 1
   int       m_div [2] = '{4, 1};
   int       m_cnt [2];
   int       m_pre [2];
   bit       m_pp  [2];
   int       m_pl  [2];
   bit       m_ap  [2];
   int       m_al  [2];
   bit       m_flag[2];
   bit       m_arm [2];
   bit       m_ie  [2];

   int    n_checks = 0;
   int    n_fail = 0;
   int    cycles = 0;
   string cur_req = "R1";

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         m_cnt[k] = 16'hFFFC; m_pre[k] = 0; m_pp[k] = 0; m_pl[k] = 0;
         m_ap[k] = 0; m_al[k] = 0; m_flag[k] = 0; m_arm[k] = 0; m_ie[k] = 0;
      end
   endtask

   initial model_reset();

   function automatic logic [7:0] exp_rd(int k);
      if (!rd_en) return 8'h00;
      case (reg_addr)
         3'd0: return 8'((m_cnt[k] >> 8) & 255);
         3'd1: return m_pp[k] ? 8'(m_pl[k]) : 8'(m_cnt[k] & 255);
         3'd2: return 8'((m_cnt[k] >> 8) & 255);
         3'd3: return m_ap[k] ? 8'(m_al[k]) : 8'(m_cnt[k] & 255);
         3'd4: return m_flag[k] ? 8'h80 : 8'h00;
         3'd5: return m_ie[k] ? 8'h01 : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         for (int k = 0; k < 2; k++) begin
            bit tk, wrp, clr, hi0, lo0, hi1, lo1, st;
            hi0 = rd_en && reg_addr == 3'd0;
            lo0 = rd_en && reg_addr == 3'd1;
            hi1 = rd_en && reg_addr == 3'd2;
            lo1 = rd_en && reg_addr == 3'd3;
            st  = rd_en && reg_addr == 3'd4;
            tk  = (m_pre[k] == m_div[k] - 1);
            wrp = tk && m_cnt[k] == 16'hFFFF;
            clr = m_arm[k] && lo0;
            if (hi0 && !m_pp[k]) begin m_pl[k] = m_cnt[k] & 255; m_pp[k] = 1; end
            else if (lo0) m_pp[k] = 0;
            if (hi1 && !m_ap[k]) begin m_al[k] = m_cnt[k] & 255; m_ap[k] = 1; end
            else if (lo1) m_ap[k] = 0;
            if (wrp) begin m_flag[k] = 1; m_arm[k] = 0; end
            else if (clr) begin m_flag[k] = 0; m_arm[k] = 0; end
            else if (st && m_flag[k]) m_arm[k] = 1;
            if (wr_en && reg_addr == 3'd5) m_ie[k] = wr_data[0];
            m_pre[k] = tk ? 0 : m_pre[k] + 1;
            if (tk) m_cnt[k] = (m_cnt[k] + 1) & 16'hFFFF;
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog %s: act=%0d cycles exp<=%0d", cur_req, cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step(logic [2:0] a, logic r, logic w, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; rd_en = r; wr_en = w; wr_data = d;
      #1;
      chk({cur_req, " rd_data slow"}, rd_slow, exp_rd(0));
      chk({cur_req, " rd_data fast"}, rd_fast, exp_rd(1));
      chk({cur_req, " irq slow"}, {7'd0, irq_slow}, {7'd0, m_flag[0] & m_ie[0]});
      chk({cur_req, " irq fast"}, {7'd0, irq_fast}, {7'd0, m_flag[1] & m_ie[1]});
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(3'd0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic rd(logic [2:0] a);
      step(a, 1'b1, 1'b0, 8'h00);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      step(a, 1'b0, 1'b1, d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, literal values, slow instance before its first step
      cur_req = "R1";
      rd(3'd0); chk("R1 high byte after reset", rd_slow, 8'hFF);
      rd(3'd1); chk("R1 low byte after reset", rd_slow, 8'hFC);
      rd(3'd4); chk("R1 status after reset", rd_slow, 8'h00);
      chk("R1 irq after reset", {7'd0, irq_slow}, 8'h00);
      rd(3'd5); chk("R11 control after reset", rd_slow, 8'h00);
      // R2 stepping every fourth edge, compared cycle by cycle
      cur_req = "R2";
      wr(3'd5, 8'h01);
      idle(12);
      // R6 wrap sets flag; R7 irq follows enable
      cur_req = "R6";
      rd(3'd4); chk("R6 status after wrap", rd_slow, 8'h80);
      chk("R7 irq with enable", {7'd0, irq_slow}, 8'h01);
      // R3 writes ignored on counter and status addresses
      cur_req = "R3";
      for (int a = 0; a < 5; a++) wr(3'(a), 8'h5A);
      rd(3'd4); chk("R3 flag kept after writes", rd_slow, 8'h80);
      // R8 handshake: status then high reads keep flag, alternate low keeps it
      cur_req = "R8";
      rd(3'd4);
      rd(3'd0);
      chk("R8 high read keeps irq", {7'd0, irq_slow}, 8'h01);
      rd(3'd3);
      chk("R9 alt low read keeps irq", {7'd0, irq_slow}, 8'h01);
      rd(3'd1);
      rd(3'd4); chk("R8 status after clear", rd_slow, 8'h00);
      chk("R8 irq after clear", {7'd0, irq_slow}, 8'h00);
      // R5 latching with repeated high reads
      cur_req = "R5";
      rd(3'd0); idle(9); rd(3'd0); idle(5); rd(3'd1);
      rd(3'd0); idle(3); rd(3'd1);
      // R4 live low byte
      cur_req = "R4";
      for (int i = 0; i < 7; i++) rd(3'd1);
      // R9 interleaved pairs
      cur_req = "R9";
      rd(3'd2); rd(3'd0); idle(6); rd(3'd3); idle(2); rd(3'd1);
      rd(3'd3); rd(3'd0); rd(3'd2); idle(5); rd(3'd1); rd(3'd3);
      // R11 unused addresses and idle strobe
      cur_req = "R11";
      rd(3'd6); chk("R11 address 6 reads zero", rd_slow, 8'h00);
      rd(3'd7); chk("R11 address 7 reads zero", rd_slow, 8'h00);
      // R7 disable path
      cur_req = "R7";
      wr(3'd5, 8'h00); rd(3'd5); chk("R7 control readback", rd_slow, 8'h00);
      wr(3'd5, 8'h01);
      // R10 collision on the fast instance (third wrap)
      cur_req = "R10";
      while (!m_flag[1]) idle(1);
      chk("R6 fast flag on second wrap", {7'd0, irq_fast}, 8'h01);
      while (m_cnt[1] != 16'hFFFE) idle(1);
      rd(3'd4);
      rd(3'd1);
      rd(3'd1);
      rd(3'd4); chk("R10 flag survives collision", rd_fast, 8'h80);
      chk("R10 irq survives collision", {7'd0, irq_fast}, 8'h01);
      rd(3'd1);
      rd(3'd4); chk("R10 re-armed clear", rd_fast, 8'h00);
      idle(4);
      finish_run();
   end
endmodule